// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is the control engine of a single DMA channel. It counts data items and blocks of one transaction, decides how many beats a single request is worth, and hands beats one by one to a datapath through a request/done handshake. A transaction has a programmable number of blocks, and each block has a programmable number of items. A request can come from a software request pulse, a burst request line or a single-item request line. Each of the two hardware request kinds has one line for the transmit direction and one for the receive direction.

The request mode sets how much one burst or software request moves: one item, the rest of the current block, or everything left in the transaction. Requests that arrive while the channel is busy are held pending. Hardware requests get an acknowledge pulse, either when the request is taken or when its work is done. Three sticky status flags report item, block and transaction completion, and each can be masked into a single interrupt line. The size registers are sampled only when a transaction starts, so software can program the next transfer while the current one runs.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, `beat_req`, `req_ack`, `txn_active`, `irq` and all three `st_flags` bits are 0.
- R2: With `cfg_mode` = 0 or 3 (item mode), each burst or software request produces exactly one beat.
- R3: With `cfg_mode` = 1 (block mode), a burst or software request produces beats up to and including the last item of the current block.
- R4: With `cfg_mode` = 2 (whole mode), a burst or software request produces beats until the transaction's last item.
- R5: A single-item hardware request produces exactly one beat in every mode.
- R6: `cfg_dir` = 0 listens to bit 0 (transmit) of both hardware request buses, and `cfg_dir` = 1 listens to bit 1 (receive). The other bit has no effect. `sw_req` works in both directions.
- R7: While `cfg_enable` is 0, requests are ignored and any pending request is discarded, so re-enabling starts no beat.
- R8: A request that arrives while a unit of work is in progress is held and then serviced, so no request is lost.
- R9: A transaction has `cfg_blk_cnt`+1 blocks of `cfg_item_cnt`+1 items each. These values are captured when a transaction starts, and changes made during the transaction take effect at the next one.
- R10: `st_flags` bit 0 (item), bit 1 (block) and bit 2 (transaction) are set by the corresponding completing beat. They stay set until written 1 on the matching `st_clr` bit. `irq` is the OR of the flags ANDed with `irq_mask`.
- R11: If `cfg_enable` drops while a unit is in progress, the beat in flight completes and the channel goes idle. The transaction is abandoned, no flag is set, and the next request starts a new transaction.
- R12: With `cfg_ack_at_end` = 0, a hardware request gets one `req_ack` pulse in the first cycle its work runs. With `cfg_ack_at_end` = 1, it gets the pulse in the cycle after its work ends. Software requests get no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Channel enable |
| cfg_mode | input | 2 | 0/3 item, 1 block, 2 whole transaction |
| cfg_dir | input | 1 | 0 transmit lines, 1 receive lines |
| cfg_ack_at_end | input | 1 | 0 acknowledge at accept, 1 at completion |
| cfg_blk_cnt | input | BLK_W | Blocks per transaction minus one |
| cfg_item_cnt | input | ITEM_W | Items per block minus one |
| sw_req | input | 1 | Software request pulse |
| hw_burst_req | input | 2 | Burst requests, bit 0 transmit, bit 1 receive |
| hw_single_req | input | 2 | Single-item requests, bit 0 transmit, bit 1 receive |
| req_ack | output | 1 | Acknowledge pulse toward the peripheral |
| beat_req | output | 1 | Beat move request to the datapath |
| beat_done | input | 1 | Datapath finished the requested beat |
| txn_active | output | 1 | A transaction is open |
| st_clr | input | 3 | Write-1 clear of the status flags |
| irq_mask | input | 3 | Interrupt enable per flag |
| st_flags | output | 3 | Item, block, transaction flags |
| irq | output | 1 | Interrupt |

## Verification
The hardest case to reach is a disable that lands in the middle of a long unit. A datapath that answers at once leaves only a few cycles per beat, so the bench starts a whole-mode transfer of many beats and drops the enable several cycles in. It then checks that the channel stops within a cycle or two, that the beat count falls short of the full transaction, that no transaction flag appears, and that a new request opens a new transaction. Requests arriving while the channel is busy are reached by pulsing a second request right after the first, and by random datapath stalls that stretch each unit over many cycles.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
    typedef enum logic [1:0] {
        UNIT_ITEM  = 2'd0,
        UNIT_BLOCK = 2'd1,
        UNIT_ALL   = 2'd2
    } unit_e;

    typedef enum logic [1:0] {
        SRC_HW_BURST  = 2'd0,
        SRC_SW        = 2'd1,
        SRC_HW_SINGLE = 2'd2
    } src_e;

    localparam int FLAG_ITEM = 0;
    localparam int FLAG_BLK  = 1;
    localparam int FLAG_TXN  = 2;
    localparam int NFLAGS    = 3;
endpackage

// File: rtl/dma_seq_req.sv
module dma_seq_req
    import dma_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       dir,
    input  logic       sw_req,
    input  logic [1:0] hw_burst_req,
    input  logic [1:0] hw_single_req,
    input  logic       take,
    output logic       pend_valid,
    output src_e       pend_src
);
    typedef struct packed {
        logic burst;
        logic sw;
        logic single;
    } pend_t;

    pend_t pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        if (take) begin
            if (pend_q.burst)   pend_d.burst  = 1'b0;
            else if (pend_q.sw) pend_d.sw     = 1'b0;
            else                pend_d.single = 1'b0;
        end
        pend_d.burst  = pend_d.burst  | hw_burst_req[dir];
        pend_d.sw     = pend_d.sw     | sw_req;
        pend_d.single = pend_d.single | hw_single_req[dir];
        if (!enable) pend_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend_valid = pend_q.burst | pend_q.sw | pend_q.single;
    assign pend_src   = pend_q.burst ? SRC_HW_BURST :
                        pend_q.sw    ? SRC_SW : SRC_HW_SINGLE;

    // R7: a disabled channel keeps nothing pending
    p_drop_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !pend_valid);
endmodule

// File: rtl/dma_seq_flags.sv
module dma_seq_flags
    import dma_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NFLAGS-1:0] set,
    input  logic [NFLAGS-1:0] clr,
    input  logic [NFLAGS-1:0] mask,
    output logic [NFLAGS-1:0] flags,
    output logic              irq
);
    logic [NFLAGS-1:0] flags_d, flags_q;

    always_comb begin
        flags_d = (flags_q & ~clr) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;
    assign irq   = |(flags_q & mask);

    // R10: a transaction end is always also a block end
    p_txn_implies_blk_r10: assert property (@(posedge clk) disable iff (!rst_n)
        set[FLAG_TXN] |-> set[FLAG_BLK]);

    for (genvar i = 0; i < NFLAGS; i++) begin : g_sticky
        // R10: flags stay set unless cleared
        p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_q[i] && !clr[i]) |=> flags_q[i]);
    end
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_seq_pkg::*;
#(
    parameter int BLK_W  = 8,
    parameter int ITEM_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_dir,
    input  logic              cfg_ack_at_end,
    input  logic [BLK_W-1:0]  cfg_blk_cnt,
    input  logic [ITEM_W-1:0] cfg_item_cnt,
    input  logic              sw_req,
    input  logic [1:0]        hw_burst_req,
    input  logic [1:0]        hw_single_req,
    output logic              req_ack,
    output logic              beat_req,
    input  logic              beat_done,
    output logic              txn_active,
    input  logic [2:0]        st_clr,
    input  logic [2:0]        irq_mask,
    output logic [2:0]        st_flags,
    output logic              irq
);
    localparam int ICW = ITEM_W + 1;
    localparam int BCW = BLK_W + 1;
    localparam logic [ICW-1:0] ONE_I = ICW'(1);
    localparam logic [BCW-1:0] ONE_B = BCW'(1);

    typedef struct packed {
        logic           busy;
        logic           in_txn;
        unit_e          unit;
        logic           unit_hw;
        logic           ack;
        logic [ICW-1:0] item_len;
        logic [ICW-1:0] items_left;
        logic [BCW-1:0] blks_left;
    } seq_t;

    seq_t st_d, st_q;
    logic [NFLAGS-1:0] flag_set;
    logic              take;
    logic              pend_valid;
    src_e              pend_src;
    logic              last_item, last_blk, unit_end;

    dma_seq_req u_req (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (cfg_enable),
        .dir           (cfg_dir),
        .sw_req        (sw_req),
        .hw_burst_req  (hw_burst_req),
        .hw_single_req (hw_single_req),
        .take          (take),
        .pend_valid    (pend_valid),
        .pend_src      (pend_src)
    );

    always_comb begin
        st_d      = st_q;
        st_d.ack  = 1'b0;
        flag_set  = '0;
        take      = 1'b0;
        last_item = (st_q.items_left == ONE_I);
        last_blk  = (st_q.blks_left == ONE_B);
        unit_end  = 1'b0;
        if (st_q.busy) begin
            if (beat_done) begin
                if (!cfg_enable) begin
                    st_d.busy   = 1'b0;
                    st_d.in_txn = 1'b0;
                end else begin
                    flag_set[FLAG_ITEM] = 1'b1;
                    unit_end = (st_q.unit == UNIT_ITEM);
                    if (last_item) begin
                        flag_set[FLAG_BLK] = 1'b1;
                        st_d.items_left = st_q.item_len;
                        st_d.blks_left  = st_q.blks_left - ONE_B;
                        if (st_q.unit == UNIT_BLOCK) unit_end = 1'b1;
                        if (last_blk) begin
                            flag_set[FLAG_TXN] = 1'b1;
                            st_d.in_txn = 1'b0;
                            unit_end    = 1'b1;
                        end
                    end else begin
                        st_d.items_left = st_q.items_left - ONE_I;
                    end
                    if (unit_end) begin
                        st_d.busy = 1'b0;
                        st_d.ack  = st_q.unit_hw & cfg_ack_at_end;
                    end
                end
            end
        end else if (!cfg_enable) begin
            st_d.in_txn = 1'b0;
        end else if (pend_valid) begin
            take         = 1'b1;
            st_d.busy    = 1'b1;
            st_d.unit_hw = (pend_src != SRC_SW);
            st_d.ack     = (pend_src != SRC_SW) & ~cfg_ack_at_end;
            if (pend_src == SRC_HW_SINGLE || cfg_mode == 2'd0 || cfg_mode == 2'd3)
                st_d.unit = UNIT_ITEM;
            else if (cfg_mode == 2'd1)
                st_d.unit = UNIT_BLOCK;
            else
                st_d.unit = UNIT_ALL;
            if (!st_q.in_txn) begin
                st_d.in_txn     = 1'b1;
                st_d.item_len   = {1'b0, cfg_item_cnt} + ONE_I;
                st_d.items_left = {1'b0, cfg_item_cnt} + ONE_I;
                st_d.blks_left  = {1'b0, cfg_blk_cnt} + ONE_B;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.unit <= UNIT_ITEM;
        end else begin
            st_q <= st_d;
        end
    end

    dma_seq_flags u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_set),
        .clr   (st_clr),
        .mask  (irq_mask),
        .flags (st_flags),
        .irq   (irq)
    );

    assign beat_req   = st_q.busy;
    assign req_ack    = st_q.ack;
    assign txn_active = st_q.in_txn;

    // R9: work only runs inside an open transaction
    p_busy_in_txn_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> st_q.in_txn);
    // R3: an open transaction never has an empty item counter
    p_items_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.in_txn |-> (st_q.items_left != '0));
    // R2: an item unit ends right after its one beat
    p_item_one_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.unit == UNIT_ITEM && beat_done) |=> !st_q.busy);
    // R7: a disabled idle channel stays idle
    p_disabled_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_enable && !st_q.busy) |=> !st_q.busy);
    // R11: a beat completing while disabled leaves the channel idle and closed
    p_abort_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && beat_done && !cfg_enable) |=> (!st_q.busy && !st_q.in_txn));
endmodule

// File: tb/dma_chan_seq_bench.sv
module dma_chan_seq_bench;
    localparam int BLK_W  = 8;
    localparam int ITEM_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_enable = 1'b0;
    logic [1:0] cfg_mode = 2'd0;
    logic cfg_dir = 1'b0;
    logic cfg_ack_at_end = 1'b0;
    logic [BLK_W-1:0]  cfg_blk_cnt = '0;
    logic [ITEM_W-1:0] cfg_item_cnt = '0;
    logic sw_req = 1'b0;
    logic [1:0] hw_burst_req = '0;
    logic [1:0] hw_single_req = '0;
    logic req_ack, beat_req, txn_active, irq;
    logic beat_done = 1'b0;
    logic [2:0] st_clr = '0;
    logic [2:0] irq_mask = '0;
    logic [2:0] st_flags;

    always #4 clk = ~clk;

    dma_chan_seq #(.BLK_W(BLK_W), .ITEM_W(ITEM_W)) u_dma_chan_seq (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_mode(cfg_mode),
        .cfg_dir(cfg_dir), .cfg_ack_at_end(cfg_ack_at_end), .cfg_blk_cnt(cfg_blk_cnt),
        .cfg_item_cnt(cfg_item_cnt), .sw_req(sw_req), .hw_burst_req(hw_burst_req),
        .hw_single_req(hw_single_req), .req_ack(req_ack), .beat_req(beat_req),
        .beat_done(beat_done), .txn_active(txn_active), .st_clr(st_clr),
        .irq_mask(irq_mask), .st_flags(st_flags), .irq(irq)
    );

    int n_chk = 0, n_fail = 0;
    int beats_seen = 0, acks_seen = 0;
    logic ack_with_busy = 1'b0;
    logic stall_en = 1'b0;
    logic finished = 1'b0;
    int cyc = 0;

    // model of the open transaction
    int m_in_txn = 0, m_item_len = 0, m_items = 0, m_blks = 0;

    // datapath model: pick beat_done, then count the fire at the coming edge
    always @(negedge clk) begin
        beat_done = stall_en ? (($urandom % 3) != 0) : 1'b1;
        if (beat_req && beat_done) beats_seen++;
        if (req_ack) begin
            acks_seen++;
            ack_with_busy = beat_req;
        end
    end

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse(int kind, int line);
        @(negedge clk);
        if (kind == 0) sw_req = 1'b1;
        else if (kind == 1) hw_burst_req[line] = 1'b1;
        else hw_single_req[line] = 1'b1;
        @(negedge clk);
        sw_req = 1'b0;
        hw_burst_req = '0;
        hw_single_req = '0;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        int n = 0;
        while (quiet < 4 && n < 3000) begin
            @(negedge clk);
            n++;
            if (beat_req) quiet = 0;
            else quiet++;
        end
    endtask

    task automatic clr_flags();
        @(negedge clk);
        st_clr = 3'b111;
        @(negedge clk);
        st_clr = 3'b000;
    endtask

    function automatic int unit_of(int kind);
        if (kind == 2 || cfg_mode == 2'd0 || cfg_mode == 2'd3) return 0;
        if (cfg_mode == 2'd1) return 1;
        return 2;
    endfunction

    task automatic model_unit(int unit, output int beats, output logic [2:0] fl);
        int done = 0;
        if (m_in_txn == 0) begin
            m_in_txn = 1;
            m_item_len = int'(cfg_item_cnt) + 1;
            m_items = m_item_len;
            m_blks = int'(cfg_blk_cnt) + 1;
        end
        beats = 0;
        fl = 3'b000;
        while (done == 0) begin
            beats++;
            fl[0] = 1'b1;
            if (m_items == 1) begin
                fl[1] = 1'b1;
                m_items = m_item_len;
                m_blks--;
                if (m_blks == 0) begin
                    fl[2] = 1'b1;
                    m_in_txn = 0;
                    done = 1;
                end
                if (unit == 1) done = 1;
            end else begin
                m_items--;
            end
            if (unit == 0) done = 1;
        end
    endtask

    task automatic run_unit(int kind, string req);
        int eb;
        logic [2:0] ef;
        clr_flags();
        beats_seen = 0;
        acks_seen = 0;
        model_unit(unit_of(kind), eb, ef);
        pulse(kind, int'(cfg_dir));
        wait_idle();
        check({req, " beats"}, beats_seen, eb);
        check({req, " flags"}, int'(st_flags), int'(ef));
        check({req, " acks (R12)"}, acks_seen, (kind != 0) ? 1 : 0);
        check({req, " txn_active (R9)"}, int'(txn_active), m_in_txn);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 beat_req", int'(beat_req), 0);
        check("R1 req_ack", int'(req_ack), 0);
        check("R1 txn_active", int'(txn_active), 0);
        check("R1 st_flags", int'(st_flags), 0);
        check("R1 irq", int'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk);
        cfg_enable = 1'b1;
        cfg_item_cnt = 16'd2;
        cfg_blk_cnt = 8'd1;

        cfg_mode = 2'd0; run_unit(0, "R2 item mode");
        cfg_mode = 2'd1; run_unit(0, "R3 block rest");
        cfg_mode = 2'd2; run_unit(0, "R4 whole rest");
        run_unit(2, "R5 single in whole mode");
        run_unit(1, "R4 whole hw burst");

        // R6: unselected direction line has no effect
        cfg_dir = 1'b0;
        beats_seen = 0;
        pulse(1, 1);
        pulse(2, 1);
        wait_idle();
        check("R6 rx line ignored when dir=0", beats_seen, 0);
        cfg_dir = 1'b1;
        run_unit(1, "R6 rx burst when dir=1");
        cfg_dir = 1'b0;

        // R7: disabled requests are ignored and dropped
        @(negedge clk);
        cfg_enable = 1'b0;
        m_in_txn = 0;
        beats_seen = 0;
        pulse(0, 0);
        pulse(1, 0);
        wait_idle();
        check("R7 no beats while disabled", beats_seen, 0);
        @(negedge clk);
        cfg_enable = 1'b1;
        wait_idle();
        check("R7 nothing pending after enable", beats_seen, 0);

        // R8: request during busy is held and serviced
        cfg_mode = 2'd0;
        clr_flags();
        beats_seen = 0;
        stall_en = 1'b1;
        begin
            int b1, b2;
            logic [2:0] f1, f2;
            model_unit(0, b1, f1);
            model_unit(0, b2, f2);
            pulse(0, 0);
            pulse(0, 0);
            wait_idle();
            check("R8 both requests serviced", beats_seen, b1 + b2);
        end
        stall_en = 1'b0;

        // R9: finish transaction, start new, change sizes mid-way
        cfg_mode = 2'd2; run_unit(0, "R9 close txn");
        cfg_mode = 2'd0; run_unit(0, "R9 open txn");
        @(negedge clk);
        cfg_item_cnt = 16'd0;
        cfg_blk_cnt = 8'd0;
        cfg_mode = 2'd2; run_unit(0, "R9 old sizes kept");
        run_unit(0, "R9 new sizes used");

        // R10: sticky flags, masks, write-1 clear per bit
        check("R10 all flags set", int'(st_flags), 7);
        irq_mask = 3'b000; @(negedge clk);
        check("R10 irq masked", int'(irq), 0);
        irq_mask = 3'b100; @(negedge clk);
        check("R10 irq from txn flag", int'(irq), 1);
        st_clr = 3'b100; @(negedge clk); st_clr = 3'b000; @(negedge clk);
        check("R10 only txn flag cleared", int'(st_flags), 3);
        check("R10 irq after clear", int'(irq), 0);
        irq_mask = 3'b001; @(negedge clk);
        check("R10 irq from item flag", int'(irq), 1);
        irq_mask = 3'b000;

        // R11: disable in mid-transfer
        cfg_item_cnt = 16'd3;
        cfg_blk_cnt = 8'd3;
        cfg_mode = 2'd2;
        clr_flags();
        beats_seen = 0;
        pulse(0, 0);
        repeat (5) @(negedge clk);
        cfg_enable = 1'b0;
        repeat (2) @(negedge clk);
        check("R11 stopped", int'(beat_req), 0);
        check("R11 txn closed", int'(txn_active), 0);
        check("R11 no txn flag", int'(st_flags[2]), 0);
        n_chk++;
        if (beats_seen >= 16 || beats_seen == 0) begin
            n_fail++;
            $display("FAIL R11 beats: actual %0d expected 1..15", beats_seen);
        end
        clr_flags();
        check("R11 no flag from aborted beat", int'(st_flags), 0);
        cfg_enable = 1'b1;
        m_in_txn = 0;
        cfg_mode = 2'd0;
        run_unit(0, "R11 fresh txn after abort");
        check("R11 fresh txn beats left", m_items, 3);

        // R12: acknowledge timing
        cfg_ack_at_end = 1'b0;
        run_unit(1, "R12 ack at accept");
        check("R12 ack while busy", int'(ack_with_busy), 1);
        cfg_ack_at_end = 1'b1;
        run_unit(1, "R12 ack at end");
        check("R12 ack after busy", int'(ack_with_busy), 0);
        run_unit(0, "R12 sw no ack");

        // random mix
        stall_en = 1'b1;
        for (int i = 0; i < 40; i++) begin
            int kind;
            cfg_mode = 2'($urandom % 4);
            cfg_ack_at_end = 1'($urandom % 2);
            if (($urandom % 4) == 0) begin
                cfg_item_cnt = 16'($urandom % 4);
                cfg_blk_cnt = 8'($urandom % 4);
            end
            cfg_dir = 1'($urandom % 2);
            kind = int'($urandom % 3);
            case (cfg_mode)
                2'd1: run_unit(kind, "R3 random");
                2'd2: run_unit(kind, "R4 random");
                default: run_unit(kind, "R2 random");
            endcase
        end
        stall_en = 1'b0;

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !finished) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule